// File: doc/BRIEF.md
# UART Interrupt Identification and Prioritisation

This block sits beside the register file of a 16550-style serial port. It decides which pending interrupt source software sees, presents that choice as an 8-bit identification value, and drives a level interrupt line. Its inputs are status flags produced elsewhere in the UART: the line error flags, receive data ready, receive FIFO occupancy and trigger level, the character-timeout flag, and the modem delta flags. It also takes strobes for an enable-register write, a transmit-holding write, an identification read and a transmitter-completion event.

The enable register lives here, and so does the hidden "transmit holding empty" pending flag. That flag is needed because the transmit-empty interrupt can be acknowledged by reading the identification value, even though the holding register is still empty. The FIFOs, the shifters and the modem pins are outside the block.

The identification value and the interrupt line are registered. They reflect the strobes and status seen at a clock edge from that edge onward.

Top module: `uart_irq_id`

## Requirements
- R1: After reset the enable readback is 0x00, the identification value reads 0x01 and `irqOut` is low.
- R2: An enable write stores only `ierWrData[3:0]`, and `ierRdData[7:4]` always reads zero. The bit meanings are: bit 0 receive data and timeout, bit 1 transmit holding empty, bit 2 line status, bit 3 modem status.
- R3: The identification code in bits 3:0 follows a fixed priority order. From highest to lowest: line status 0x6, character timeout 0xC, receive data 0x4, transmit holding empty 0x2, modem status 0x0. When nothing is pending the code is 0x1.
- R4: The line status code is selected when enable bit 2 is set and any bit of `lineErr` is set.
- R5: The character timeout code is selected only when `timeoutPend` is set and enable bit 0 is set.
- R6: The receive data code needs enable bit 0 and `dataReady`. With `fifoOn` high it also needs `rxCount >= trigLevel`. With `fifoOn` low, `dataReady` alone is enough.
- R7: The transmit-empty pending flag is set in two cases: by an enable write while `thrEmpty` is high, and by `txDoneEn` while `thrEmpty` is high. It is cleared by `thrWrEn` and by `iirRdEn`. A clear in the same cycle as a set wins. The transmit-empty code needs this flag and enable bit 1.
- R8: Bits 7:6 of the identification value are both 1 when `fifoOn` is high and both 0 otherwise. Bits 5:4 are zero.
- R9: `irqOut` is high exactly when the identification code is not 0x1.
- R10: The identification value and `irqOut` change only at a clock edge. They reflect the inputs and strobes sampled at that edge. During an `iirRdEn` cycle `iirRdData` still shows the value from before the read clears the pending flag.
- R11: The modem status code is selected when enable bit 3 is set and any bit of `modemDelta` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ierWrEn | input | 1 | Enable register write strobe |
| ierWrData | input | 8 | Enable register write data |
| thrWrEn | input | 1 | Transmit holding register write strobe |
| iirRdEn | input | 1 | Identification value read strobe |
| txDoneEn | input | 1 | Transmitter finished a character |
| thrEmpty | input | 1 | Transmit holding register empty status |
| lineErr | input | NUM_ERR | Overrun, parity, framing and break flags (any order) |
| dataReady | input | 1 | Receive data available |
| fifoOn | input | 1 | FIFO mode enabled |
| rxCount | input | CNT_W | Receive FIFO occupancy |
| trigLevel | input | CNT_W | Receive FIFO trigger level |
| timeoutPend | input | 1 | Character timeout pending |
| modemDelta | input | NUM_DELTA | Modem status change flags |
| ierRdData | output | 8 | Enable register readback |
| iirRdData | output | 8 | Identification value |
| irqOut | output | 1 | Level interrupt request |

## Verification
The bench uses the default CNT_W of 5, so that FIFO occupancies from 0 to 16 can be driven. Trigger levels are drawn from 1, 4, 8 and 14. This places the count below, at and above each trigger, which exercises the qualified receive-data path on both sides of the comparison. NUM_ERR and NUM_DELTA stay at 4. Random mixes of all five sources and colliding set and clear strobes let every priority pairing and the clear-wins rule of the pending flag occur many times.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int IER_W = 4;
  localparam int EN_RX    = 0;
  localparam int EN_THRE  = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  typedef enum logic [3:0] {
    ID_MODEM   = 4'h0,
    ID_NONE    = 4'h1,
    ID_THRE    = 4'h2,
    ID_RXDATA  = 4'h4,
    ID_LINE    = 4'h6,
    ID_TIMEOUT = 4'hC
  } irqId_e;

  // Strobes from the control half to the datapath: next-state values.
  typedef struct packed {
    logic [IER_W-1:0] ierNext;
    logic             threPendNext;
  } ctrlStrobe_t;
endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ierWrEn,
  input  logic [7:0]  ierWrData,
  input  logic        thrWrEn,
  input  logic        iirRdEn,
  input  logic        txDoneEn,
  input  logic        thrEmpty,
  output ctrlStrobe_t strobes,
  output logic [7:0]  ierRdData
);
  logic [IER_W-1:0] ierReg;
  logic             pendReg;
  logic             armPend;
  logic             dropPend;
  logic [3:0]       unusedIerHi;

  assign unusedIerHi = ierWrData[7:4];

  always_comb begin
    armPend  = (ierWrEn || txDoneEn) && thrEmpty;
    dropPend = thrWrEn || iirRdEn;
    strobes.ierNext      = ierWrEn ? ierWrData[IER_W-1:0] : ierReg;
    strobes.threPendNext = dropPend ? 1'b0 : (armPend ? 1'b1 : pendReg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ierReg  <= '0;
      pendReg <= 1'b0;
    end else begin
      ierReg  <= strobes.ierNext;
      pendReg <= strobes.threPendNext;
    end
  end

  assign ierRdData = {{(8-IER_W){1'b0}}, ierReg};
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [IER_W-1:0] ier,
  input  logic             threPend,
  input  logic             lineHit,
  input  logic             tmoHit,
  input  logic             rxHit,
  input  logic             deltaHit,
  output irqId_e           code
);
  always_comb begin
    if (ier[EN_LINE] && lineHit)        code = ID_LINE;
    else if (ier[EN_RX] && tmoHit)      code = ID_TIMEOUT;
    else if (ier[EN_RX] && rxHit)       code = ID_RXDATA;
    else if (ier[EN_THRE] && threPend)  code = ID_THRE;
    else if (ier[EN_MODEM] && deltaHit) code = ID_MODEM;
    else                                code = ID_NONE;
  end
endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int NUM_ERR   = 4,
  parameter int NUM_DELTA = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobes,
  input  logic [NUM_ERR-1:0]   lineErr,
  input  logic                 dataReady,
  input  logic                 fifoOn,
  input  logic [CNT_W-1:0]     rxCount,
  input  logic [CNT_W-1:0]     trigLevel,
  input  logic                 timeoutPend,
  input  logic [NUM_DELTA-1:0] modemDelta,
  output logic [7:0]           iirRdData,
  output logic                 irqOut
);
  logic   lineHit;
  logic   deltaHit;
  logic   rxHit;
  irqId_e code;
  logic [7:0] iirReg;
  logic       irqReg;

  always_comb begin
    lineHit  = |lineErr;
    deltaHit = |modemDelta;
    rxHit    = dataReady && (!fifoOn || (rxCount >= trigLevel));
  end

  uart_irq_prio prio_i (
    .ier      (strobes.ierNext),
    .threPend (strobes.threPendNext),
    .lineHit  (lineHit),
    .tmoHit   (timeoutPend),
    .rxHit    (rxHit),
    .deltaHit (deltaHit),
    .code     (code)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iirReg <= {4'h0, ID_NONE};
      irqReg <= 1'b0;
    end else begin
      iirReg <= {{2{fifoOn}}, 2'b00, code};
      irqReg <= (code != ID_NONE);
    end
  end

  assign iirRdData = iirReg;
  assign irqOut    = irqReg;
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int NUM_ERR   = 4,
  parameter int NUM_DELTA = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ierWrEn,
  input  logic [7:0]           ierWrData,
  input  logic                 thrWrEn,
  input  logic                 iirRdEn,
  input  logic                 txDoneEn,
  input  logic                 thrEmpty,
  input  logic [NUM_ERR-1:0]   lineErr,
  input  logic                 dataReady,
  input  logic                 fifoOn,
  input  logic [CNT_W-1:0]     rxCount,
  input  logic [CNT_W-1:0]     trigLevel,
  input  logic                 timeoutPend,
  input  logic [NUM_DELTA-1:0] modemDelta,
  output logic [7:0]           ierRdData,
  output logic [7:0]           iirRdData,
  output logic                 irqOut
);
  ctrlStrobe_t strobes;

  uart_irq_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .ierWrEn   (ierWrEn),
    .ierWrData (ierWrData),
    .thrWrEn   (thrWrEn),
    .iirRdEn   (iirRdEn),
    .txDoneEn  (txDoneEn),
    .thrEmpty  (thrEmpty),
    .strobes   (strobes),
    .ierRdData (ierRdData)
  );

  uart_irq_dp #(.CNT_W(CNT_W), .NUM_ERR(NUM_ERR), .NUM_DELTA(NUM_DELTA)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .lineErr     (lineErr),
    .dataReady   (dataReady),
    .fifoOn      (fifoOn),
    .rxCount     (rxCount),
    .trigLevel   (trigLevel),
    .timeoutPend (timeoutPend),
    .modemDelta  (modemDelta),
    .iirRdData   (iirRdData),
    .irqOut      (irqOut)
  );
endmodule

// File: rtl/uart_irq_id_chk.sv
module uart_irq_id_chk #(
  parameter int CNT_W     = 5,
  parameter int NUM_ERR   = 4,
  parameter int NUM_DELTA = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 ierWrEn,
  input logic [7:0]           ierWrData,
  input logic                 thrWrEn,
  input logic                 iirRdEn,
  input logic                 fifoOn,
  input logic [NUM_ERR-1:0]   lineErr,
  input logic                 timeoutPend,
  input logic [NUM_DELTA-1:0] modemDelta,
  input logic [CNT_W-1:0]     rxCount,
  input logic [7:0]           ierRdData,
  input logic [7:0]           iirRdData,
  input logic                 irqOut
);
  logic [CNT_W-1:0] unusedCnt;
  logic             unusedTmo;
  logic [NUM_DELTA-1:0] unusedDelta;
  assign unusedCnt   = rxCount;
  assign unusedTmo   = timeoutPend;
  assign unusedDelta = modemDelta;

  a_r2_ier_store: assert property (@(posedge clk) disable iff (!rstN)
    ierWrEn |=> (ierRdData == {4'h0, $past(ierWrData[3:0])}));

  a_r4_line_first: assert property (@(posedge clk) disable iff (!rstN)
    (!ierWrEn && ierRdData[2] && (|lineErr)) |=> (iirRdData[3:0] == 4'h6));

  a_r5_rx_gate: assert property (@(posedge clk) disable iff (!rstN)
    (!ierWrEn && !ierRdData[0]) |=> (iirRdData[3:0] != 4'hC && iirRdData[3:0] != 4'h4));

  a_r7_thr_clear: assert property (@(posedge clk) disable iff (!rstN)
    (thrWrEn || iirRdEn) |=> (iirRdData[3:0] != 4'h2));

  a_r8_fifo_bits: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (iirRdData[7:6] == {2{$past(fifoOn)}} && iirRdData[5:4] == 2'b00));

  a_r9_irq_level: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (iirRdData[3:0] != 4'h1));

  a_r11_modem_lowest: assert property (@(posedge clk) disable iff (!rstN)
    (!ierWrEn && ierRdData[3:0] == 4'h8 && (|modemDelta)) |=> (iirRdData[3:0] == 4'h0));
endmodule

bind uart_irq_id uart_irq_id_chk #(.CNT_W(CNT_W), .NUM_ERR(NUM_ERR), .NUM_DELTA(NUM_DELTA)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .ierWrEn     (ierWrEn),
  .ierWrData   (ierWrData),
  .thrWrEn     (thrWrEn),
  .iirRdEn     (iirRdEn),
  .fifoOn      (fifoOn),
  .lineErr     (lineErr),
  .timeoutPend (timeoutPend),
  .modemDelta  (modemDelta),
  .rxCount     (rxCount),
  .ierRdData   (ierRdData),
  .iirRdData   (iirRdData),
  .irqOut      (irqOut)
);

// File: tb/uart_irq_id_tb_top.sv
module uart_irq_id_tb_top;
  localparam int CNT_W = 5;
  localparam int NE    = 4;
  localparam int ND    = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ierWrEn = 0, thrWrEn = 0, iirRdEn = 0, txDoneEn = 0, thrEmpty = 0;
  logic [7:0] ierWrData = 0;
  logic [NE-1:0] lineErr = 0;
  logic dataReady = 0, fifoOn = 0, timeoutPend = 0;
  logic [CNT_W-1:0] rxCount = 0, trigLevel = 1;
  logic [ND-1:0] modemDelta = 0;
  logic [7:0] ierRdData, iirRdData;
  logic irqOut;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  logic [3:0] mIer = 0;
  logic       mPend = 0;
  logic [7:0] mIir = 8'h01;
  logic       mIrq = 0;

  always #2 clk = ~clk;

  uart_irq_id #(.CNT_W(CNT_W), .NUM_ERR(NE), .NUM_DELTA(ND)) dut_i (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog expired: actual=%0d cycles expected<=100000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [3:0] expCode(logic [3:0] ier, logic pend);
    logic rxOk;
    rxOk = dataReady && (!fifoOn || rxCount >= trigLevel);
    if (ier[2] && |lineErr)         return 4'h6;
    else if (ier[0] && timeoutPend) return 4'hC;
    else if (ier[0] && rxOk)        return 4'h4;
    else if (ier[1] && pend)        return 4'h2;
    else if (ier[3] && |modemDelta) return 4'h0;
    return 4'h1;
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  // Update model from the current inputs, cross one edge, compare.
  task automatic step(string tag);
    logic [3:0] code;
    if (ierWrEn) mIer = ierWrData[3:0];
    if (thrWrEn || iirRdEn) mPend = 1'b0;
    else if ((ierWrEn || txDoneEn) && thrEmpty) mPend = 1'b1;
    code = expCode(mIer, mPend);
    mIir = {{2{fifoOn}}, 2'b00, code};
    mIrq = (code != 4'h1);
    @(posedge clk);
    @(negedge clk);
    check({tag, " iir"}, iirRdData, mIir);
    check("R9 irq", {7'd0, irqOut}, {7'd0, mIrq});
    check("R2 ier", ierRdData, {4'h0, mIer});
  endtask

  task automatic idle();
    ierWrEn = 0; thrWrEn = 0; iirRdEn = 0; txDoneEn = 0;
  endtask

  function automatic string codeTag(logic [3:0] c);
    case (c)
      4'h6: return "R4";
      4'hC: return "R5";
      4'h4: return "R6";
      4'h2: return "R7";
      4'h0: return "R11";
      default: return "R3";
    endcase
  endfunction

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1357);
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1 iir", iirRdData, 8'h01);
    check("R1 irq", {7'd0, irqOut}, 8'h00);
    check("R1 ier", ierRdData, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    // R2/R7: write all ones with THR empty -> only low nibble, pending armed
    thrEmpty = 1; ierWrEn = 1; ierWrData = 8'hFF;
    step("R7 arm");
    check("R2 upper zero", ierRdData, 8'h0F);
    check("R7 thre code", iirRdData, 8'h02);
    idle();
    // R10: read sees value before clear
    iirRdEn = 1;
    #1 check("R10 read sample", iirRdData, 8'h02);
    step("R7 read clear");
    check("R7 cleared", iirRdData, 8'h01);
    idle();
    // R3/R4: all sources pending -> line status wins
    lineErr = 4'b0100; timeoutPend = 1; dataReady = 1; modemDelta = 4'b0001;
    step("R4 line");
    check("R4 line wins", iirRdData, 8'h06);
    lineErr = 0;
    step("R5 timeout");
    check("R5 timeout next", iirRdData, 8'h0C);
    // R5: timeout gated by enable bit 0
    ierWrEn = 1; ierWrData = 8'h0A; thrEmpty = 0;
    step("R5 gate");
    idle();
    check("R11 modem only", iirRdData, 8'h00);
    timeoutPend = 0;
    // R6/R8: FIFO mode trigger qualification
    ierWrEn = 1; ierWrData = 8'h01; fifoOn = 1; trigLevel = 8; rxCount = 7;
    step("R6 below");
    idle();
    check("R6 below trig", iirRdData, 8'hC1);
    rxCount = 8;
    step("R6 at");
    check("R6 at trig", iirRdData, 8'hC4);
    fifoOn = 0; rxCount = 0;
    step("R8 fifo off");
    check("R8 fifo off data", iirRdData, 8'h04);
    dataReady = 0;
    // R7: set and clear collide -> clear wins; txDone arms
    ierWrEn = 1; ierWrData = 8'h02; thrEmpty = 1; thrWrEn = 1;
    step("R7 collide");
    idle();
    check("R7 clear wins", iirRdData, 8'h01);
    txDoneEn = 1;
    step("R7 txdone");
    idle();
    check("R7 txdone arms", iirRdData, 8'h02);
    modemDelta = 0;

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      int t;
      ierWrEn   = ($urandom % 6) == 0;
      ierWrData = 8'($urandom);
      thrWrEn   = ($urandom % 7) == 0;
      iirRdEn   = ($urandom % 7) == 0;
      txDoneEn  = ($urandom % 5) == 0;
      thrEmpty  = $urandom % 2;
      lineErr   = (($urandom % 4) == 0) ? NE'($urandom) : '0;
      dataReady = $urandom % 2;
      fifoOn    = ($urandom % 3) != 0;
      rxCount   = CNT_W'($urandom % 17);
      t = $urandom % 4;
      trigLevel = (t == 0) ? 5'd1 : (t == 1) ? 5'd4 : (t == 2) ? 5'd8 : 5'd14;
      timeoutPend = ($urandom % 4) == 0;
      modemDelta  = (($urandom % 3) == 0) ? ND'($urandom) : '0;
      if (iirRdEn) #1 check("R10 read sample", iirRdData, mIir);
      begin
        logic [3:0] peek;
        logic [3:0] nIer;
        logic nPend;
        nIer = ierWrEn ? ierWrData[3:0] : mIer;
        nPend = (thrWrEn || iirRdEn) ? 1'b0 : (((ierWrEn || txDoneEn) && thrEmpty) ? 1'b1 : mPend);
        peek = expCode(nIer, nPend);
        step({codeTag(peek), " R3 random"});
      end
    end
    idle();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule